// File: doc/BRIEF.md
# Four-State Snooping Coherence Line Controller

This block keeps the coherence state of a small set of cache lines on a shared snooping bus. Each line is in one of four states: Invalid, Shared, Owned or Modified. The local processor sends read, write and evict requests on one port. The block answers each request with a hit/miss response. When a request needs the bus, the block issues a bus transaction. An evict of dirty data raises a memory write-back request.

On a second port the block watches transactions that other caches put on the bus. It updates its lines in response. When it holds the only current copy of a line, it supplies that data cache-to-cache with a flush. A remote read of a Modified line does not write the dirty data back to memory. Instead the line moves to Owned, keeps the dirty data and serves later readers from the cache. Only an evict of a Modified or Owned line sends data to memory.

Lines are selected by an index, one state per index. `NUM_LINES` must be a power of two. All outputs are registered and appear one clock after the request or snoop that causes them. A snoop and a local request in the same cycle are both accepted. When they target the same line, the snoop is applied first.

Top module: `mosi_coherence_ctrl`

## Requirements
- R1: After reset every line is Invalid, and all valid and strobe outputs are low until a request or snoop arrives.
- R2: Every local request (op code 0 read, 1 write, 2 evict, 3 probe) produces `cpu_resp_valid` exactly one cycle later. `cpu_hit` is 1 when the line was valid at that time. A probe changes no state and issues nothing.
- R3: A local read of an Invalid line issues bus command 0 (read) and the line becomes Shared. A local write of an Invalid line issues bus command 1 (read-exclusive) and the line becomes Modified.
- R4: A local write to a Shared or Owned line issues bus command 2 (upgrade) and the line becomes Modified.
- R5: Local reads and writes of a Modified line, and local reads of Shared or Owned lines, issue no bus transaction.
- R6: A snooped read (command 0) of a Modified line moves it to Owned. It raises `flush_valid` with that line's index one cycle later and raises no write-back.
- R7: A snooped read of an Owned line raises a flush and leaves the line Owned. A snooped read of a Shared or Invalid line causes no action.
- R8: A snooped read-exclusive (command 1) invalidates the line. A Modified or Owned line also raises a flush; a Shared line does not.
- R9: A snooped upgrade (command 2) invalidates any valid line without a flush.
- R10: A snooped flush (command 3) has no effect on any line.
- R11: Evicting a Modified or Owned line raises `wb_req` with its index one cycle later. Evicting a Shared or Invalid line raises none. An evicted line is always Invalid afterwards.
- R12: When a snoop and a local request target the same line in one cycle, the local request sees the state left by the snoop.
- R13: A snoop to one line and a local request to a different line in the same cycle are handled independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Local request present |
| cpu_op | input | 2 | Local op: 0 read, 1 write, 2 evict, 3 probe |
| cpu_idx | input | IDX_W | Line index of the local request |
| cpu_resp_valid | output | 1 | Response strobe, one cycle after the request |
| cpu_hit | output | 1 | Line was valid when the request was handled |
| bus_valid | output | 1 | Bus transaction issued |
| bus_cmd | output | 2 | Issued command: 0 read, 1 read-exclusive, 2 upgrade |
| bus_idx | output | IDX_W | Line index of the issued transaction |
| snoop_valid | input | 1 | Snooped transaction present |
| snoop_cmd | input | 2 | Snooped command: 0 read, 1 read-exclusive, 2 upgrade, 3 flush |
| snoop_idx | input | IDX_W | Line index of the snooped transaction |
| flush_valid | output | 1 | Cache-to-cache data supply for a snooped request |
| flush_idx | output | IDX_W | Line index being flushed |
| wb_req | output | 1 | Memory write-back request |
| wb_idx | output | IDX_W | Line index to write back |

## Verification
Some properties are checked on every cycle:
- At most one line flushes at a time.
- Responses and write-backs only follow the requests that cause them.
- An upgrade is only issued for a local write.
- A snooped read of a Modified line ends in Owned with a flush.
- A snooped invalidation leaves the line Invalid unless a local request to the same line follows it.

The dirty-data lifecycle can only be shown by bench scenarios. In those, a line goes from Modified to Owned, serves repeated readers, is upgraded again and is finally evicted with a write-back. The scenarios also cover the ignored flush snoop and the ordering when a snoop and a local request collide on one line.

// File: rtl/mosi_pkg.sv
package mosi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_O = 2'd2,
        ST_M = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_RD    = 2'd0,
        BUS_RDX   = 2'd1,
        BUS_UPGR  = 2'd2,
        BUS_FLUSH = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_PROBE = 2'd3
    } cpu_op_e;

    function automatic logic is_dirty(line_state_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

endpackage

// File: rtl/mosi_snoop_line.sv
module mosi_snoop_line
    import mosi_pkg::*;
(
    input  line_state_e cur_st,
    input  logic        sel,
    input  bus_cmd_e    cmd,
    output line_state_e nxt_st,
    output logic        flush
);

    always_comb begin
        nxt_st = cur_st;
        flush  = 1'b0;
        if (sel) begin
            unique case (cmd)
                BUS_RD: begin
                    if (is_dirty(cur_st)) begin
                        flush  = 1'b1;
                        nxt_st = ST_O;
                    end
                end
                BUS_RDX: begin
                    flush  = is_dirty(cur_st);
                    nxt_st = ST_I;
                end
                BUS_UPGR: begin
                    nxt_st = ST_I;
                end
                default: begin
                    nxt_st = cur_st;
                end
            endcase
        end
    end

endmodule

// File: rtl/mosi_local_fsm.sv
module mosi_local_fsm
    import mosi_pkg::*;
(
    input  line_state_e cur_st,
    input  logic        req,
    input  cpu_op_e     op,
    output line_state_e nxt_st,
    output logic        hit,
    output logic        bus_req,
    output bus_cmd_e    bus_cmd,
    output logic        wb
);

    always_comb begin
        nxt_st  = cur_st;
        hit     = req && (cur_st != ST_I);
        bus_req = 1'b0;
        bus_cmd = BUS_RD;
        wb      = 1'b0;
        if (req) begin
            unique case (op)
                OP_READ: begin
                    if (cur_st == ST_I) begin
                        bus_req = 1'b1;
                        bus_cmd = BUS_RD;
                        nxt_st  = ST_S;
                    end
                end
                OP_WRITE: begin
                    if (cur_st == ST_I) begin
                        bus_req = 1'b1;
                        bus_cmd = BUS_RDX;
                    end else if (cur_st != ST_M) begin
                        bus_req = 1'b1;
                        bus_cmd = BUS_UPGR;
                    end
                    nxt_st = ST_M;
                end
                OP_EVICT: begin
                    wb     = is_dirty(cur_st);
                    nxt_st = ST_I;
                end
                default: begin
                    nxt_st = cur_st;
                end
            endcase
        end
    end

endmodule

// File: rtl/mosi_coherence_ctrl.sv
module mosi_coherence_ctrl
    import mosi_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_resp_valid,
    output logic             cpu_hit,
    output logic             bus_valid,
    output logic [1:0]       bus_cmd,
    output logic [IDX_W-1:0] bus_idx,
    input  logic             snoop_valid,
    input  logic [1:0]       snoop_cmd,
    input  logic [IDX_W-1:0] snoop_idx,
    output logic             flush_valid,
    output logic [IDX_W-1:0] flush_idx,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx
);

    typedef struct packed {
        line_state_e [NUM_LINES-1:0] st;
        logic                        resp_v;
        logic                        hit;
        logic                        bus_v;
        logic [1:0]                  bus_cmd;
        logic [IDX_W-1:0]            bus_idx;
        logic                        flush_v;
        logic [IDX_W-1:0]            flush_idx;
        logic                        wb_v;
        logic [IDX_W-1:0]            wb_idx;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    line_state_e            st_snp [NUM_LINES];
    logic [NUM_LINES-1:0]   line_flush;

    line_state_e loc_cur, loc_nxt;
    logic        loc_hit, loc_bus, loc_wb;
    bus_cmd_e    loc_cmd;

    // Snoop stage: one responder per line.
    for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
        mosi_snoop_line i_snoop (
            .cur_st (ctrl_q.st[gi]),
            .sel    (snoop_valid && (snoop_idx == IDX_W'(gi))),
            .cmd    (bus_cmd_e'(snoop_cmd)),
            .nxt_st (st_snp[gi]),
            .flush  (line_flush[gi])
        );
    end

    // Local stage works on the post-snoop state.
    assign loc_cur = st_snp[cpu_idx];

    mosi_local_fsm i_local (
        .cur_st  (loc_cur),
        .req     (cpu_valid),
        .op      (cpu_op_e'(cpu_op)),
        .nxt_st  (loc_nxt),
        .hit     (loc_hit),
        .bus_req (loc_bus),
        .bus_cmd (loc_cmd),
        .wb      (loc_wb)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            ctrl_d.st[i] = st_snp[i];
        end
        if (cpu_valid) begin
            ctrl_d.st[cpu_idx] = loc_nxt;
        end
        ctrl_d.resp_v    = cpu_valid;
        ctrl_d.hit       = loc_hit;
        ctrl_d.bus_v     = loc_bus;
        ctrl_d.bus_cmd   = loc_bus ? loc_cmd : 2'd0;
        ctrl_d.bus_idx   = loc_bus ? cpu_idx : '0;
        ctrl_d.flush_v   = |line_flush;
        ctrl_d.flush_idx = (|line_flush) ? snoop_idx : '0;
        ctrl_d.wb_v      = loc_wb;
        ctrl_d.wb_idx    = loc_wb ? cpu_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign cpu_resp_valid = ctrl_q.resp_v;
    assign cpu_hit        = ctrl_q.hit;
    assign bus_valid      = ctrl_q.bus_v;
    assign bus_cmd        = ctrl_q.bus_cmd;
    assign bus_idx        = ctrl_q.bus_idx;
    assign flush_valid    = ctrl_q.flush_v;
    assign flush_idx      = ctrl_q.flush_idx;
    assign wb_req         = ctrl_q.wb_v;
    assign wb_idx         = ctrl_q.wb_idx;

    // Assertions

    assert_flush_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_flush));

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_resp_valid |-> $past(cpu_valid));

    assert_wb_only_on_evict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> $past(cpu_valid && cpu_op == OP_EVICT));

    assert_upgr_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == BUS_UPGR) |-> $past(cpu_valid && cpu_op == OP_WRITE));

    assert_rd_on_mod_owns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && snoop_cmd == BUS_RD && ctrl_q.st[snoop_idx] == ST_M
         && !(cpu_valid && cpu_idx == snoop_idx))
        |=> (flush_valid && flush_idx == $past(snoop_idx)
             && ctrl_q.st[$past(snoop_idx)] == ST_O));

    assert_snoop_invalidates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_valid && (snoop_cmd == BUS_RDX || snoop_cmd == BUS_UPGR)
         && !(cpu_valid && cpu_idx == snoop_idx))
        |=> ctrl_q.st[$past(snoop_idx)] == ST_I);

endmodule

// File: tb/test_mosi_coherence_ctrl.sv
module test_mosi_coherence_ctrl;

    localparam int N = 8;
    localparam int W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0;
    logic [1:0] cpu_op = 2'd0;
    logic [W-1:0] cpu_idx = '0;
    logic cpu_resp_valid, cpu_hit, bus_valid, flush_valid, wb_req;
    logic [1:0] bus_cmd;
    logic [W-1:0] bus_idx, flush_idx, wb_idx;
    logic snoop_valid = 1'b0;
    logic [1:0] snoop_cmd = 2'd0;
    logic [W-1:0] snoop_idx = '0;

    always #2 clk = ~clk;

    mosi_coherence_ctrl #(.NUM_LINES(N)) i_mosi_coherence_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .cpu_resp_valid(cpu_resp_valid), .cpu_hit(cpu_hit),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_idx(bus_idx),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_idx(snoop_idx),
        .flush_valid(flush_valid), .flush_idx(flush_idx),
        .wb_req(wb_req), .wb_idx(wb_idx)
    );

    // Encodings from the requirements.
    localparam bit [1:0] I = 0, S = 1, O = 2, M = 3;
    localparam bit [1:0] RD = 0, WR = 1, EV = 2, PR = 3;
    localparam bit [1:0] C_RD = 0, C_RDX = 1, C_UPGR = 2, C_FLUSH = 3;

    typedef struct {
        bit rv, hit, bv;
        bit [1:0] cmd;
        bit [W-1:0] bidx;
        bit fv;
        bit [W-1:0] fidx;
        bit wv;
        bit [W-1:0] widx;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    bit [1:0] model [N];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic step(bit cv, bit [1:0] op, int ci, bit sv, bit [1:0] sc, int si, string tag);
        exp_t e;
        bit [1:0] s;
        @(negedge clk);
        cpu_valid = cv; cpu_op = op; cpu_idx = W'(ci);
        snoop_valid = sv; snoop_cmd = sc; snoop_idx = W'(si);
        e = '{rv:0, hit:0, bv:0, cmd:0, bidx:0, fv:0, fidx:0, wv:0, widx:0, tag:tag};
        if (sv) begin
            s = model[si];
            if (sc == C_RD && (s == M || s == O)) begin
                e.fv = 1; e.fidx = W'(si); model[si] = O;
            end else if (sc == C_RDX) begin
                if (s == M || s == O) begin e.fv = 1; e.fidx = W'(si); end
                model[si] = I;
            end else if (sc == C_UPGR) begin
                model[si] = I;
            end
        end
        if (cv) begin
            s = model[ci];
            e.rv = 1;
            e.hit = (s != I);
            if (op == RD && s == I) begin
                e.bv = 1; e.cmd = C_RD; e.bidx = W'(ci); model[ci] = S;
            end else if (op == WR) begin
                if (s == I) begin e.bv = 1; e.cmd = C_RDX; e.bidx = W'(ci); end
                else if (s != M) begin e.bv = 1; e.cmd = C_UPGR; e.bidx = W'(ci); end
                model[ci] = M;
            end else if (op == EV) begin
                if (s == M || s == O) begin e.wv = 1; e.widx = W'(ci); end
                model[ci] = I;
            end
        end
        exp_q.push_back(e);
    endtask

    task automatic local_req(bit [1:0] op, int ci, string tag);
        step(1, op, ci, 0, 0, 0, tag);
    endtask

    task automatic snoop(bit [1:0] sc, int si, string tag);
        step(0, 0, 0, 1, sc, si, tag);
    endtask

    // Monitor: compares each queued item one edge after it was driven.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            bit bad;
            e = exp_q.pop_front();
            bad = (cpu_resp_valid !== e.rv) || (e.rv && cpu_hit !== e.hit)
               || (bus_valid !== e.bv) || (e.bv && (bus_cmd !== e.cmd || bus_idx !== e.bidx))
               || (flush_valid !== e.fv) || (e.fv && flush_idx !== e.fidx)
               || (wb_req !== e.wv) || (e.wv && wb_idx !== e.widx);
            checks++;
            if (bad) begin
                fails++;
                $display("FAIL %s: actual rv=%0b hit=%0b bus=%0b/%0d/%0d flush=%0b/%0d wb=%0b/%0d expected rv=%0b hit=%0b bus=%0b/%0d/%0d flush=%0b/%0d wb=%0b/%0d",
                    e.tag, cpu_resp_valid, cpu_hit, bus_valid, bus_cmd, bus_idx,
                    flush_valid, flush_idx, wb_req, wb_idx,
                    e.rv, e.hit, e.bv, e.cmd, e.bidx, e.fv, e.fidx, e.wv, e.widx);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = I;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (cpu_resp_valid || bus_valid || flush_valid || wb_req) begin
            fails++;
            $display("FAIL R1: actual strobes %0b%0b%0b%0b expected 0000",
                     cpu_resp_valid, bus_valid, flush_valid, wb_req);
        end
        for (int i = 0; i < N; i++) local_req(RD, i, "R1 R3 read miss from reset");
        for (int i = 0; i < N; i++) local_req(EV, i, "R11 evict shared");
        local_req(EV, 0, "R11 evict invalid");
        local_req(PR, 0, "R2 probe invalid");

        local_req(WR, 0, "R3 write miss");
        local_req(RD, 0, "R5 read hit M");
        local_req(WR, 0, "R5 write hit M");
        local_req(PR, 0, "R2 probe M");
        snoop(C_RD, 0, "R6 snoop read on M");
        local_req(RD, 0, "R5 read hit O");
        snoop(C_RD, 0, "R7 snoop read on O");
        local_req(WR, 0, "R4 write on O");
        snoop(C_RD, 0, "R6 snoop read on M again");
        local_req(EV, 0, "R11 evict O");
        local_req(RD, 0, "R11 line invalid after evict");

        local_req(RD, 1, "R3 read miss");
        snoop(C_RD, 1, "R7 snoop read on S");
        local_req(RD, 1, "R5 read hit S");
        local_req(WR, 1, "R4 write on S");
        snoop(C_RDX, 1, "R8 snoop rdx on M");
        local_req(RD, 1, "R8 line invalid");

        local_req(RD, 2, "R3 read miss");
        snoop(C_RDX, 2, "R8 snoop rdx on S");
        local_req(RD, 2, "R8 line invalid");
        local_req(WR, 2, "R3 write miss");
        snoop(C_RD, 2, "R6 to O");
        snoop(C_RDX, 2, "R8 snoop rdx on O");
        local_req(PR, 2, "R8 probe invalid");

        local_req(WR, 3, "R3 write miss");
        snoop(C_UPGR, 3, "R9 snoop upgrade on M");
        local_req(RD, 3, "R9 line invalid");
        snoop(C_UPGR, 3, "R9 snoop upgrade on S");
        local_req(PR, 3, "R9 probe invalid");

        local_req(WR, 4, "R3 write miss");
        snoop(C_FLUSH, 4, "R10 snoop flush on M");
        local_req(RD, 4, "R10 still valid");
        local_req(EV, 4, "R10 still dirty");

        snoop(C_RD, 5, "R7 snoop read on I");
        local_req(PR, 5, "R7 probe I");

        local_req(WR, 6, "R3 write miss");
        step(1, RD, 6, 1, C_RDX, 6, "R12 collision rdx then read");
        local_req(WR, 6, "R12 line became S");
        step(1, EV, 6, 1, C_RD, 6, "R12 collision read then evict");

        local_req(WR, 5, "R3 write miss");
        step(1, WR, 7, 1, C_RD, 5, "R13 independent lines");
        local_req(EV, 5, "R13 line 5 owned");
        local_req(RD, 7, "R13 line 7 modified");

        step(0, 0, 0, 0, 0, 0, "R1 idle");
        step(0, 0, 0, 0, 0, 0, "R1 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule